// File: doc/BRIEF.md
# Three-Channel Interval Timer

This block holds three independent 16-bit up-counters that run from one shared clock. Each channel has a power-of-two prescaler, a control word that starts, stops and zeroes the count, a readable count, a limit register, a two-bit event status word and a matching interrupt mask. A channel either runs free, wrapping from the top count back to zero, or runs in interval mode, where it restarts from zero each time it passes its programmed limit. A shared register port (write strobe, read strobe, byte address, 16-bit data) reaches every channel, and each channel drives its own interrupt line.

All registers of one kind form a bank, and the three channels of a bank sit at consecutive 4-byte steps from the bank base. The bank bases are clock setup 0x00, control 0x0C, count 0x18, limit 0x24, status 0x54 and mask 0x60. Read data is combinational from the address, so a read returns its value in the cycle the strobe is high. A status read acknowledges the flags it returns at the end of that cycle.

The asynchronous active-low reset is released through a two-stage synchronizer, so the channels leave reset two clock edges after `rst_n` rises.

Top module: `tri_timer`

## Requirements
- R1: After reset every channel reads clock setup 0, control 0x0001 (stopped, free mode), count 0, limit 0xFFFF, status 0 and mask 0, and all interrupt lines are low.
- R2: Control bit 0 set stops the channel and holds the count. Control bit 0 clear lets it run. With the prescaler off, the count rises by one on every clock edge.
- R3: In clock setup, bit 0 turns the prescaler on and bits [4:1] hold an exponent N. With the prescaler on, the count advances once every 2^(N+1) clocks, and the first advance after a count restart lands 2^(N+1) edges after the restarting write.
- R4: A control write with bit 4 set zeroes the count and the prescaler phase on that same edge. Bits 0 and 1 take the written value on that edge. Control keeps only bits 0 and 1, so bit 4 and the other bits read back 0.
- R5: With control bit 1 clear (free mode), an advance from 0xFFFF gives 0 and sets status bit 1. Status bit 0 is never set in this mode.
- R6: With control bit 1 set (interval mode), an advance taken while the count equals the limit gives 0 and sets status bit 0.
- R7: A channel's interrupt line is high while any status bit is set together with the same bit in its mask. Mask bit 0 goes with status bit 0 (interval) and mask bit 1 with status bit 1 (rollover).
- R8: A status read returns the pending flags and clears them on that edge. An event on the same edge stays pending.
- R9: The register of kind K for channel c sits at bank base of K plus 4*c. The channels count, flag and interrupt independently of one another.
- R10: Writes to the count and status banks change nothing, and reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared timer and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Byte address of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; a status read clears the flags |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr, valid in the same cycle |
| irq | output | 3 | One interrupt line per channel |

## Verification
The bench builds the block with its defaults: three channels, a 16-bit count and a 4-bit exponent field. A 16-bit count lets one full free-running wrap, 65536 ticks, fit in the run, so the rollover flag and its interrupt are observed at the real top count. An exponent of 1 gives a divide-by-four ratio, short enough to check the exact edges of the first and later advances after a restart. An interval limit of 4 keeps interval periods to five ticks, so a status read can be placed on the exact edge of a new event.

// File: rtl/tri_timer_pkg.sv
package tri_timer_pkg;

  // Bank bases of each register kind and the step between channels
  localparam int unsigned BASE_CLK = 32'h00;
  localparam int unsigned BASE_CTL = 32'h0C;
  localparam int unsigned BASE_CNT = 32'h18;
  localparam int unsigned BASE_LIM = 32'h24;
  localparam int unsigned BASE_STS = 32'h54;
  localparam int unsigned BASE_MSK = 32'h60;
  localparam int unsigned CH_STEP  = 4;

  // Bit of the control word that zeroes the count
  localparam int unsigned CTL_ZERO_BIT = 4;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_CLK,
    RK_CTL,
    RK_CNT,
    RK_LIM,
    RK_STS,
    RK_MSK
  } reg_kind_e;

  // Stored control bits; packed order puts halt in bit 0, mode in bit 1
  typedef struct packed {
    logic lim_mode;
    logic halt;
  } ctl_t;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int EXP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             div_en,
  input  logic [EXP_W-1:0] div_exp,
  output logic             tick
);
  localparam int PHASE_W = 2 ** EXP_W;

  logic [PHASE_W-1:0] phase_q;
  logic [PHASE_W-1:0] phase_d;
  logic [PHASE_W-1:0] mask;

  always_comb begin
    mask    = ~({PHASE_W{1'b1}} << (32'(div_exp) + 32'd1));
    tick    = div_en ? ((phase_q & mask) == mask) : 1'b1;
    phase_d = clr ? '0 : phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  // R3
  div_no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_en) |=> !(tick && div_en && $stable(div_exp)));

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tri_timer_pkg::*;
#(
  parameter int CH_IDX = 0,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8,
  parameter int EXP_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  rd_data,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_CLK = ADDR_W'(BASE_CLK + CH_STEP * CH_IDX);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(BASE_CTL + CH_STEP * CH_IDX);
  localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(BASE_CNT + CH_STEP * CH_IDX);
  localparam logic [ADDR_W-1:0] A_LIM = ADDR_W'(BASE_LIM + CH_STEP * CH_IDX);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(BASE_STS + CH_STEP * CH_IDX);
  localparam logic [ADDR_W-1:0] A_MSK = ADDR_W'(BASE_MSK + CH_STEP * CH_IDX);
  localparam logic [CNT_W-1:0]  CNT_TOP = '1;

  reg_kind_e        kind;
  logic [EXP_W:0]   clk_q, clk_d;
  ctl_t             ctl_q, ctl_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] lim_q, lim_d;
  logic [1:0]       sts_q, sts_d;
  logic [1:0]       msk_q, msk_d;
  logic             we_clk, we_ctl, we_lim, we_msk;
  logic             zero_wr, sts_ack;
  logic             tick, evt_lim, evt_top;

  // Address decode for this channel
  always_comb begin
    if      (bus_addr == A_CLK) kind = RK_CLK;
    else if (bus_addr == A_CTL) kind = RK_CTL;
    else if (bus_addr == A_CNT) kind = RK_CNT;
    else if (bus_addr == A_LIM) kind = RK_LIM;
    else if (bus_addr == A_STS) kind = RK_STS;
    else if (bus_addr == A_MSK) kind = RK_MSK;
    else                        kind = RK_NONE;
  end

  assign we_clk  = bus_wr && (kind == RK_CLK);
  assign we_ctl  = bus_wr && (kind == RK_CTL);
  assign we_lim  = bus_wr && (kind == RK_LIM);
  assign we_msk  = bus_wr && (kind == RK_MSK);
  assign zero_wr = we_ctl && bus_wdata[CTL_ZERO_BIT];
  assign sts_ack = bus_rd && (kind == RK_STS);

  tmr_prescaler #(.EXP_W(EXP_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (ctl_q.halt || zero_wr),
    .div_en  (clk_q[0]),
    .div_exp (clk_q[EXP_W:1]),
    .tick    (tick)
  );

  // Configuration next state
  always_comb begin
    clk_d = we_clk ? bus_wdata[EXP_W:0] : clk_q;
    ctl_d = ctl_q;
    if (we_ctl) begin
      ctl_d.halt     = bus_wdata[0];
      ctl_d.lim_mode = bus_wdata[1];
    end
    lim_d = we_lim ? bus_wdata : lim_q;
    msk_d = we_msk ? bus_wdata[1:0] : msk_q;
  end

  // Count next state and events
  always_comb begin
    cnt_d   = cnt_q;
    evt_lim = 1'b0;
    evt_top = 1'b0;
    if (zero_wr) begin
      cnt_d = '0;
    end else if (!ctl_q.halt && tick) begin
      if (ctl_q.lim_mode && (cnt_q == lim_q)) begin
        cnt_d   = '0;
        evt_lim = 1'b1;
      end else if (cnt_q == CNT_TOP) begin
        cnt_d   = '0;
        evt_top = !ctl_q.lim_mode;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    sts_d = (sts_ack ? 2'b00 : sts_q) | {evt_top, evt_lim};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q <= '0;
      ctl_q <= '{lim_mode: 1'b0, halt: 1'b1};
      cnt_q <= '0;
      lim_q <= '1;
      sts_q <= '0;
      msk_q <= '0;
    end else begin
      clk_q <= clk_d;
      ctl_q <= ctl_d;
      cnt_q <= cnt_d;
      lim_q <= lim_d;
      sts_q <= sts_d;
      msk_q <= msk_d;
    end
  end

  assign irq = |(sts_q & msk_q);

  always_comb begin
    case (kind)
      RK_CLK:  rd_data = CNT_W'(clk_q);
      RK_CTL:  rd_data = CNT_W'(ctl_q);
      RK_CNT:  rd_data = cnt_q;
      RK_LIM:  rd_data = lim_q;
      RK_STS:  rd_data = CNT_W'(sts_q);
      RK_MSK:  rd_data = CNT_W'(msk_q);
      default: rd_data = '0;
    endcase
  end

  // R2
  halt_holds_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.halt && !we_ctl) |=> $stable(cnt_q));

  // R4
  zero_write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_wr |=> (cnt_q == '0));

  // R5
  lim_flag_needs_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q[0]) |-> $past(ctl_q.lim_mode));

  // R8
  ack_clears_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_ack && !tick) |=> (sts_q == 2'b00));

endmodule

// File: rtl/tri_timer.sv
module tri_timer #(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8,
  parameter int EXP_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic [NUM_CH-1:0] irq
);
  logic [1:0]       rst_sync_q;
  logic             core_rst_n;
  logic [CNT_W-1:0] ch_rd [NUM_CH];

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    tmr_channel #(
      .CH_IDX (g),
      .CNT_W  (CNT_W),
      .ADDR_W (ADDR_W),
      .EXP_W  (EXP_W)
    ) u_ch (
      .clk       (clk),
      .rst_n     (core_rst_n),
      .bus_addr  (reg_addr),
      .bus_wr    (reg_wr),
      .bus_rd    (reg_rd),
      .bus_wdata (reg_wdata),
      .rd_data   (ch_rd[g]),
      .irq       (irq[g])
    );
  end

  // Only the addressed channel drives non-zero data
  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_CH; i++) reg_rdata = reg_rdata | ch_rd[i];
  end

endmodule

// File: tb/sim_tri_timer.sv
`timescale 1ns/1ps
module sim_tri_timer;
  localparam int STEP = 4;
  localparam logic [7:0] A_CLK = 8'h00, A_CTL = 8'h0C, A_CNT = 8'h18,
                         A_LIM = 8'h24, A_STS = 8'h54, A_MSK = 8'h60;

  typedef struct {
    logic [7:0]  addr;
    logic [15:0] exp;
    string       req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  reg_addr;
  logic        reg_wr, reg_rd;
  logic [15:0] reg_wdata, reg_rdata;
  logic [2:0]  irq;

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;
  item_t sb_q[$];

  always #10 clk = ~clk;

  tri_timer u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // Monitor: samples mid-window before the rising edge
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (reg_rd) begin
        item_t it;
        checks++;
        if (sb_q.size() == 0) begin
          fails++;
          $display("FAIL %s: read with no expected item, actual %h expected none", "R?", reg_rdata);
        end else begin
          it = sb_q.pop_front();
          if (reg_rdata !== it.exp) begin
            fails++;
            $display("FAIL %s: addr %h actual %h expected %h", it.req, it.addr, reg_rdata, it.exp);
          end
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [15:0] e, input string r);
    item_t it;
    it.addr = a; it.exp = e; it.req = r;
    sb_q.push_back(it);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic irq_chk(input int ch, input logic e, input string r);
    #5;
    checks++;
    if (irq[ch] !== e) begin
      fails++;
      $display("FAIL %s: irq[%0d] actual %b expected %b", r, ch, irq[ch], e);
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #3000000;
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 / R9: reset values at every channel address
    for (int c = 0; c < 3; c++) begin
      rd(A_CLK + 8'(STEP * c), 16'h0000, "R1");
      rd(A_CTL + 8'(STEP * c), 16'h0001, "R1");
      rd(A_CNT + 8'(STEP * c), 16'h0000, "R1");
      rd(A_LIM + 8'(STEP * c), 16'hFFFF, "R9");
      rd(A_STS + 8'(STEP * c), 16'h0000, "R1");
      rd(A_MSK + 8'(STEP * c), 16'h0000, "R1");
    end
    irq_chk(0, 1'b0, "R1");

    // R2: run from zero, one per clock, then hold when stopped
    wr(A_CTL, 16'h0010);
    rd(A_CNT, 16'd0, "R2");
    rd(A_CNT, 16'd1, "R2");
    idle(3);
    wr(A_CTL, 16'h0001);
    rd(A_CNT, 16'd6, "R2");
    idle(3);
    rd(A_CNT, 16'd6, "R2");
    // R4: zero while stopped, bit 4 reads back 0
    wr(A_CTL, 16'h0011);
    rd(A_CNT, 16'd0, "R4");
    rd(A_CTL, 16'h0001, "R4");

    // R3: channel 1, exponent 1 -> divide by 4
    wr(A_CLK + 8'(STEP), 16'h0003);
    wr(A_CTL + 8'(STEP), 16'h0010);
    idle(10);
    rd(A_CNT + 8'(STEP), 16'd2, "R3");
    rd(A_CNT + 8'(STEP), 16'd2, "R3");
    rd(A_CNT + 8'(STEP), 16'd3, "R3");
    rd(A_CLK + 8'(STEP), 16'h0003, "R3");
    rd(A_CNT, 16'd0, "R9");

    // R10: read-only banks ignore writes, unmapped reads are zero
    wr(A_CTL + 8'(STEP), 16'h0011);
    wr(A_CNT + 8'(STEP), 16'h1234);
    rd(A_CNT + 8'(STEP), 16'h0000, "R10");
    wr(A_STS + 8'(STEP), 16'h0003);
    rd(A_STS + 8'(STEP), 16'h0000, "R10");
    rd(8'h70, 16'h0000, "R10");

    // R6 / R7 / R8: channel 0 interval mode, limit 4
    wr(A_LIM, 16'd4);
    wr(A_MSK, 16'h0001);
    wr(A_CTL, 16'h0023);
    rd(A_CTL, 16'h0003, "R4");
    irq_chk(0, 1'b0, "R7");
    wr(A_CTL, 16'h0012);
    idle(3);
    rd(A_CNT, 16'd3, "R6");
    rd(A_CNT, 16'd4, "R6");
    irq_chk(0, 1'b1, "R7");
    rd(A_CNT, 16'd1, "R6");
    rd(A_STS, 16'h0001, "R8");
    irq_chk(0, 1'b0, "R8");
    rd(A_STS, 16'h0000, "R8");
    rd(A_STS, 16'h0001, "R8");
    rd(A_STS, 16'h0000, "R8");
    wr(A_MSK, 16'h0000);
    idle(4);
    irq_chk(0, 1'b0, "R7");
    rd(A_STS, 16'h0001, "R7");
    wr(A_CTL, 16'h0003);

    // R5: channel 2 free mode, full wrap
    wr(A_MSK + 8'(2 * STEP), 16'h0002);
    wr(A_CTL + 8'(2 * STEP), 16'h0010);
    idle(65534);
    rd(A_CNT + 8'(2 * STEP), 16'hFFFE, "R5");
    irq_chk(2, 1'b0, "R5");
    irq_chk(2, 1'b1, "R5");
    rd(A_STS + 8'(2 * STEP), 16'h0002, "R5");
    rd(A_STS + 8'(2 * STEP), 16'h0000, "R5");
    irq_chk(2, 1'b0, "R7");
    wr(A_CTL + 8'(2 * STEP), 16'h0001);

    idle(2);
    if (sb_q.size() != 0) begin
      checks++;
      fails++;
      $display("FAIL R?: %0d expected reads left, expected 0", sb_q.size());
    end
    finish_run();
  end
endmodule